// File: doc/BRIEF.md
# Raster Timing Generator

This block walks a beam position across a full raster frame, blanking included, one pixel per clock. A horizontal counter steps every clock and a line counter steps at each line end. Each axis runs through four regions in a fixed order: sync, back porch, active, front porch. Horizontal widths are counted in pixel clocks and vertical heights in lines. All eight widths are run-time inputs, captured once per frame. The block drives registered horizontal sync, vertical sync and data-enable outputs. It also exposes the current column and line, and gives a one-cycle start-of-active-video strobe that downstream timing logic can use as an exact frame reference.

Ten position events are decoded from the counters. Each event can be masked by an enable register. An enabled event sets a sticky status bit, and software clears that bit by writing a one to it. A latency measurement should start its timer on the active-start event, not on vertical sync. Sync leads the first visible pixel by a mode-dependent number of lines, for example 41 lines at 1920x1080p60 (sync 5, back porch 36). Every width is assumed to be at least one.

Top module: `raster_timer`

## Requirements
- R1: While reset is held, every output is zero. This covers both syncs, data enable, the start strobe, position, the enable register and the status register.
- R2: While running, the column advances by one each clock and wraps to 0 after sync+back+active+front−1. The line advances at each column wrap and wraps the same way on the vertical widths. The column and line outputs are registered: they show the counter values of the previous clock, and the first cycle after start shows column 0, line 0.
- R3: Horizontal sync is high for the first hsync columns of each line. Vertical sync is high for the first vsync lines of each frame. Both start at column 0.
- R4: Data enable is high exactly when the column lies in the horizontal active region and the line lies in the vertical active region.
- R5: The start-of-active strobe is high for a single cycle per frame. It coincides with the first visible pixel, at column hsync+hback and line vsync+vback.
- R6: Event bit positions are: 0 line sync start, 1 horizontal back porch start, 2 horizontal active start, 3 horizontal front porch start, 4 frame sync start, 5 vertical back porch start, 6 first visible pixel, 7 vertical front porch start, 8 last pixel of the frame, 9 idle. The vertical events 4, 5 and 7 occur at column 0.
- R7: A status bit is set only by an event whose enable bit is 1. Once set, it stays set until it is cleared.
- R8: Writing to the clear port clears each status bit written as 1. An event that occurs in the same cycle wins over the clear. Writing back the value just read clears everything pending.
- R9: While the run input is low, the idle event (bit 9) fires every cycle. The counters also return to zero, and the sync, enable and strobe outputs stay low.
- R10: Width inputs changed during a frame take effect only after that frame's last pixel. The running frame keeps its old geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Scan enable; low holds the block idle |
| h_sync_len | input | HW | Horizontal sync width in clocks |
| h_back_len | input | HW | Horizontal back porch in clocks |
| h_act_len | input | HW | Horizontal active width in clocks |
| h_front_len | input | HW | Horizontal front porch in clocks |
| v_sync_len | input | VW | Vertical sync height in lines |
| v_back_len | input | VW | Vertical back porch in lines |
| v_act_len | input | VW | Vertical active height in lines |
| v_front_len | input | VW | Vertical front porch in lines |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 10 | Enable register write value |
| clr_wr | input | 1 | Status clear strobe |
| clr_wdata | input | 10 | Status bits to clear (ones clear) |
| ev_en | output | 10 | Current event enable mask |
| ev_status | output | 10 | Sticky pending events |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active pixel indicator |
| sav | output | 1 | Start-of-active-video strobe |
| x_pos | output | HW+2 | Current column |
| y_pos | output | VW+2 | Current line |

## Verification
The hardest condition to reach is a geometry change made in the middle of a frame. It must not disturb that frame, and it must govern the next one. The bench starts a small mode, widens the active region partway through the first frame, and then checks two things. The first visible pixel and the wrap still follow the old line length. The second frame's line ends at the new length. Separate runs with narrow enable masks show that only the enabled event bits (first visible pixel, last pixel) collect status. The same runs show the order of the clear, sticky and write-back steps.

// File: rtl/raster_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes: event indices match the status/enable bit layout in the brief.
package raster_pkg;

    localparam int NUM_EV     = 10;
    localparam int EV_HSYNC   = 0;
    localparam int EV_HBP     = 1;
    localparam int EV_HACT    = 2;
    localparam int EV_HFP     = 3;
    localparam int EV_VSYNC   = 4;
    localparam int EV_VBP     = 5;
    localparam int EV_VACT    = 6;
    localparam int EV_VFP     = 7;
    localparam int EV_VFP_END = 8;
    localparam int EV_IDLE    = 9;

    // Position flags decoded for one axis of the raster.
    typedef struct packed {
        logic at_first;   // counter at region-sequence start (sync start)
        logic at_bp;      // first back porch position
        logic at_act;     // first active position
        logic at_fp;      // first front porch position
        logic at_last;    // last position before wrap
        logic in_sync;    // inside sync region
        logic in_act;     // inside active region
    } axis_flags_t;

endpackage

// File: rtl/raster_axis.sv
// One raster axis: a counter walking sync, back porch, active, front porch.
// Width inputs are shadowed on 'load' so a frame keeps one geometry.
// Assumes: every width is at least one; CW is wide enough for their sum.
module raster_axis
    import raster_pkg::*;
#(
    parameter int LW = 12,
    parameter int CW = LW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic          load,
    input  logic [LW-1:0] sync_len,
    input  logic [LW-1:0] bp_len,
    input  logic [LW-1:0] act_len,
    input  logic [LW-1:0] fp_len,
    output logic [CW-1:0] cnt,
    output axis_flags_t   flags
);

    logic [LW-1:0] s_sync, s_bp, s_act, s_fp;
    logic [CW-1:0] e_bp, e_act, e_fp, e_last;

    // Capture the geometry at frame boundaries or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_sync <= '0;
            s_bp   <= '0;
            s_act  <= '0;
            s_fp   <= '0;
        end else if (load) begin
            s_sync <= sync_len;
            s_bp   <= bp_len;
            s_act  <= act_len;
            s_fp   <= fp_len;
        end
    end

    // Region boundaries derived from the shadowed widths.
    always_comb begin
        e_bp   = CW'(s_sync);
        e_act  = e_bp + CW'(s_bp);
        e_fp   = e_act + CW'(s_act);
        e_last = e_fp + CW'(s_fp) - CW'(1);
    end

    // Decode the position flags from the counter.
    always_comb begin
        flags.at_first = (cnt == '0);
        flags.at_bp    = (cnt == e_bp);
        flags.at_act   = (cnt == e_act);
        flags.at_fp    = (cnt == e_fp);
        flags.at_last  = (cnt == e_last);
        flags.in_sync  = (cnt < e_bp);
        flags.in_act   = (cnt >= e_act) && (cnt < e_fp);
    end

    // Position counter: wraps after the last position, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= flags.at_last ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/raster_events.sv
// Combinational decode of the ten position events from both axes.
// Assumes: flags come from raster_axis instances of the same frame.
module raster_events
    import raster_pkg::*;
(
    input  logic              run,
    input  axis_flags_t       hf,
    input  axis_flags_t       vf,
    output logic [NUM_EV-1:0] ev
);

    // Map axis positions onto event bits.
    always_comb begin
        ev             = '0;
        ev[EV_HSYNC]   = run && hf.at_first;
        ev[EV_HBP]     = run && hf.at_bp;
        ev[EV_HACT]    = run && hf.at_act;
        ev[EV_HFP]     = run && hf.at_fp;
        ev[EV_VSYNC]   = run && hf.at_first && vf.at_first;
        ev[EV_VBP]     = run && hf.at_first && vf.at_bp;
        ev[EV_VACT]    = run && hf.at_act && vf.at_act;
        ev[EV_VFP]     = run && hf.at_first && vf.at_fp;
        ev[EV_VFP_END] = run && hf.at_last && vf.at_last;
        ev[EV_IDLE]    = !run;
    end

endmodule

// File: rtl/raster_status.sv
// Event enable mask and sticky write-one-to-clear status register.
// Assumes: an event and a clear of the same bit in one cycle leaves it set.
module raster_status
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic              en_wr,
    input  logic [NUM_EV-1:0] en_wdata,
    input  logic              clr_wr,
    input  logic [NUM_EV-1:0] clr_wdata,
    output logic [NUM_EV-1:0] en,
    output logic [NUM_EV-1:0] status
);

    logic [NUM_EV-1:0] clr_mask;

    // Clear mask is only live during a clear write.
    always_comb clr_mask = clr_wr ? clr_wdata : '0;

    // Enable register write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_wr) en <= en_wdata;
    end

    // Sticky status: clear requested bits, then set enabled events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | (ev & en);
    end

endmodule

// File: rtl/raster_timer.sv
// Raster timing generator top: two axis counters, event decode, status
// registers and registered sync / data-enable / start-of-active outputs.
// Assumes: widths are nonzero; outputs lag the counters by one register.
module raster_timer
    import raster_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12,
    localparam int HCW = HW + 2,
    localparam int VCW = VW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HW-1:0]     h_sync_len,
    input  logic [HW-1:0]     h_back_len,
    input  logic [HW-1:0]     h_act_len,
    input  logic [HW-1:0]     h_front_len,
    input  logic [VW-1:0]     v_sync_len,
    input  logic [VW-1:0]     v_back_len,
    input  logic [VW-1:0]     v_act_len,
    input  logic [VW-1:0]     v_front_len,
    input  logic              en_wr,
    input  logic [NUM_EV-1:0] en_wdata,
    input  logic              clr_wr,
    input  logic [NUM_EV-1:0] clr_wdata,
    output logic [NUM_EV-1:0] ev_en,
    output logic [NUM_EV-1:0] ev_status,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              sav,
    output logic [HCW-1:0]    x_pos,
    output logic [VCW-1:0]    y_pos
);

    logic              primed;
    logic              run_eff;
    logic              frame_end;
    logic              load;
    logic [HCW-1:0]    hcnt;
    logic [VCW-1:0]    vcnt;
    axis_flags_t       hf, vf;
    logic [NUM_EV-1:0] ev;

    // Ensure the shadows hold valid widths before the first scan.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // Scan control: effective run and the frame-boundary geometry load.
    always_comb begin
        run_eff   = run && primed;
        frame_end = run_eff && hf.at_last && vf.at_last;
        load      = !run_eff || frame_end;
    end

    raster_axis #(.LW(HW), .CW(HCW)) u_h (
        .clk(clk), .rst_n(rst_n), .run(run_eff), .step(run_eff), .load(load),
        .sync_len(h_sync_len), .bp_len(h_back_len),
        .act_len(h_act_len), .fp_len(h_front_len),
        .cnt(hcnt), .flags(hf)
    );

    raster_axis #(.LW(VW), .CW(VCW)) u_v (
        .clk(clk), .rst_n(rst_n), .run(run_eff),
        .step(run_eff && hf.at_last), .load(load),
        .sync_len(v_sync_len), .bp_len(v_back_len),
        .act_len(v_act_len), .fp_len(v_front_len),
        .cnt(vcnt), .flags(vf)
    );

    raster_events u_ev (
        .run(run_eff), .hf(hf), .vf(vf), .ev(ev)
    );

    raster_status u_st (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .en(ev_en), .status(ev_status)
    );

    // Register the video outputs and position from the current counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync <= 1'b0;
            vsync <= 1'b0;
            de    <= 1'b0;
            sav   <= 1'b0;
            x_pos <= '0;
            y_pos <= '0;
        end else begin
            hsync <= run_eff && hf.in_sync;
            vsync <= run_eff && vf.in_sync;
            de    <= run_eff && hf.in_act && vf.in_act;
            sav   <= ev[EV_VACT];
            x_pos <= run_eff ? hcnt : '0;
            y_pos <= run_eff ? vcnt : '0;
        end
    end

endmodule

// File: rtl/raster_timer_chk.sv
// Assertion checker for raster_timer, attached by bind below.
// Assumes: observes only top-level ports.
module raster_timer_chk
    import raster_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              hsync,
    input logic              vsync,
    input logic              de,
    input logic              sav,
    input logic              clr_wr,
    input logic [NUM_EV-1:0] clr_wdata,
    input logic [NUM_EV-1:0] ev_en,
    input logic [NUM_EV-1:0] ev_status
);

    // R9: stopping the scan drops every video output on the next clock.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!hsync && !vsync && !de && !sav));

    // R5: the start strobe lasts a single cycle.
    a_r5_sav_single: assert property (@(posedge clk) disable iff (!rst_n)
        sav |=> !sav);

    // R5: the start strobe marks a visible pixel.
    a_r5_sav_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        sav |-> de);

    // R3: frame sync begins on a line sync.
    a_r3_vsync_on_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> hsync);

    // R7: pending bits survive any cycle without a clear write.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((ev_status & $past(ev_status)) == $past(ev_status)));

    // R8: cleared bits that were not enabled read zero afterwards.
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((ev_status & $past(clr_wdata) & ~$past(ev_en)) == '0));

endmodule

bind raster_timer raster_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hsync(hsync), .vsync(vsync), .de(de), .sav(sav),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .ev_en(ev_en), .ev_status(ev_status)
);

// File: tb/tb_raster_timer.sv
// Bench for raster_timer using an 11x7 raster:
// h sync2 bp3 act4 fp2, v sync1 bp2 act3 fp1.
module tb_raster_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [11:0] h_sync_len = 12'd2, h_back_len = 12'd3;
    logic [11:0] h_act_len = 12'd4, h_front_len = 12'd2;
    logic [11:0] v_sync_len = 12'd1, v_back_len = 12'd2;
    logic [11:0] v_act_len = 12'd3, v_front_len = 12'd1;
    logic        en_wr = 1'b0, clr_wr = 1'b0;
    logic [9:0]  en_wdata = '0, clr_wdata = '0;
    logic [9:0]  ev_en, ev_status;
    logic        hsync, vsync, de, sav;
    logic [13:0] x_pos, y_pos;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    raster_timer dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .h_sync_len(h_sync_len), .h_back_len(h_back_len),
        .h_act_len(h_act_len), .h_front_len(h_front_len),
        .v_sync_len(v_sync_len), .v_back_len(v_back_len),
        .v_act_len(v_act_len), .v_front_len(v_front_len),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .ev_en(ev_en), .ev_status(ev_status),
        .hsync(hsync), .vsync(vsync), .de(de), .sav(sav),
        .x_pos(x_pos), .y_pos(y_pos)
    );

    always #5 clk = ~clk;

    // Vectors: cycle n after start, expected x, y, {hsync,vsync,de,sav}.
    localparam int NV = 11;
    localparam int T_N [NV] = '{0, 5, 13, 38, 39, 42, 56, 63, 66, 76, 77};
    localparam int T_X [NV] = '{0, 5,  2,  5,  6,  9,  1,  8,  0, 10,  0};
    localparam int T_Y [NV] = '{0, 0,  1,  3,  3,  3,  5,  5,  6,  6,  0};
    localparam int T_F [NV] = '{12, 4, 0,  3,  2,  0,  8,  2,  8,  0, 12};

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int flags_now();
        return {hsync, vsync, de, sav};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int idx;
        repeat (3) tick();
        // R1: reset state
        chk("R1 reset outputs", {ev_en, ev_status, hsync, vsync, de, sav, x_pos, y_pos}, 0);
        rst_n = 1'b1;
        tick();

        // R9: idle event while stopped, outputs quiet
        en_wr = 1'b1; en_wdata = 10'h200;
        tick();
        en_wr = 1'b0;
        tick();
        chk("R9 idle status", ev_status, 10'h200);
        chk("R9 idle outputs", {hsync, vsync, de, sav, x_pos, y_pos}, 0);
        en_wr = 1'b1; en_wdata = 10'h000;
        tick();
        en_wr = 1'b0; clr_wr = 1'b1; clr_wdata = 10'h200;
        tick();
        clr_wr = 1'b0;
        chk("R8 clear idle bit", ev_status, 0);

        // Pass 1: table walk over one frame plus the wrap (R2 R3 R4 R5)
        run = 1'b1;
        idx = 0;
        for (int n = 0; n <= 77; n++) begin
            tick();
            if (idx < NV && n == T_N[idx]) begin
                chk("R2 x position", int'(x_pos), T_X[idx]);
                chk("R2 y position", int'(y_pos), T_Y[idx]);
                chk("R3 R4 R5 sync/de/sav", flags_now(), T_F[idx]);
                idx++;
            end
        end
        run = 1'b0;
        tick();
        chk("R9 stop clears position", {hsync, vsync, de, x_pos, y_pos}, 0);

        // Pass 2: masked events, sticky and write-one-to-clear (R6 R7 R8)
        en_wr = 1'b1; en_wdata = 10'h140;
        tick();
        en_wr = 1'b0;
        run = 1'b1;
        for (int n = 0; n <= 76; n++) begin
            tick();
            if (n == 37) chk("R6 R7 nothing before first pixel", ev_status, 0);
            if (n == 38) chk("R6 R7 first pixel bit only", ev_status, 10'h040);
            if (n == 75) chk("R6 R7 before frame end", ev_status, 10'h040);
            if (n == 76) chk("R6 frame end bit 8", ev_status, 10'h140);
        end
        clr_wr = 1'b1; clr_wdata = 10'h040;
        tick();
        clr_wr = 1'b0;
        chk("R8 selective clear", ev_status, 10'h100);
        tick();
        chk("R7 pending bit held", ev_status, 10'h100);
        clr_wr = 1'b1; clr_wdata = ev_status;
        tick();
        clr_wr = 1'b0;
        chk("R8 write-back clears all", ev_status, 0);
        run = 1'b0;
        en_wr = 1'b1; en_wdata = 10'h000;
        tick();
        en_wr = 1'b0;

        // Pass 3: geometry change mid-frame applies at frame boundary (R10)
        run = 1'b1;
        for (int n = 0; n <= 90; n++) begin
            tick();
            if (n == 20) h_act_len = 12'd6;
            if (n == 38) chk("R10 old geometry first pixel", {x_pos[7:0], y_pos[7:0], 4'(flags_now())}, {8'd5, 8'd3, 4'd3});
            if (n == 77) chk("R10 old total wraps", {x_pos[7:0], y_pos[7:0]}, {8'd0, 8'd0});
            if (n == 89) chk("R10 new line length", {x_pos[7:0], y_pos[7:0]}, {8'd12, 8'd0});
            if (n == 90) chk("R10 new line wrap", {x_pos[7:0], y_pos[7:0]}, {8'd0, 8'd1});
        end
        run = 1'b0;
        tick();
        finish_run();
    end

endmodule